// File: doc/BRIEF.md
# Local Bus FIFO Transfer Controller

This peripheral moves a single packet between an on-chip data FIFO and a chip-select window on an external 32-bit local bus. Software fills in a byte count, a bus start address, a chip select and a transfer direction. It then issues a start command. The controller runs one 32-bit bus beat at a time until the byte count is used up. On a bus write it takes each word from the FIFO. On a bus read it places each returned word into the FIFO. The bus beat is a request/acknowledge handshake, and the FIFO storage sits outside the block.

The running byte count can be read back together with two sticky flags, one for completion and one for abort. Each flag has its own interrupt unmask bit. A set of reset bits in the enable register stops any transfer in progress and clears all progress state. The controller stays held for as long as those bits remain set.

Top module: `lbfifo_xfer`

## Requirements
- R1: After `rst`, every register reads zero, and `irq`, `lb_req`, `fifo_pop` and `fifo_push` are low. While enable bit 24 (controller reset) or bit 16 (FIFO reset) is set, the sequencer stays idle and `lb_req` is low. In that state the done flag, the abort flag and the byte count read zero, and `fifo_clr` follows bit 16.
- R2: A start happens only on a write to offset 0x00 that has byte lane 3 enabled and data bit 24 set. It also needs enable bit 0 (master) set, both reset bits clear and no transfer in progress. Byte lanes 0 to 2 of the same register hold the 24-bit packet size, and writing those lanes alone never starts a transfer.
- R3: Beat k drives `lb_addr` equal to the start address (offset 0x04) plus 4·k. `lb_cs` carries control bits 31:24 and `lb_we` is the inverse of control bit 16 (1 = read). While `lb_req` is waiting for `lb_ack`, the address holds steady.
- R4: A transfer of N bytes runs ceil(N/4) beats. The byte count at offset 0x14 bits 23:0 grows by 4 per acknowledged beat, and by the remainder on the last beat, so it ends at exactly N.
- R5: In write direction each beat pops one FIFO word, and that word appears on `lb_wdata` for the beat.
- R6: In read direction each acknowledged beat pushes `lb_rdata` into the FIFO, in beat order.
- R7: The transfer ends early in two cases: the FIFO is empty when a write-direction beat is due, or the FIFO is full when a read-direction beat is acknowledged. In either case the abort flag is set and the done flag is not, and the count covers only the beats already moved.
- R8: A read of offset 0x14 returns the abort flag in bit 28, the done flag in bit 24 and the byte count in bits 23:0. All other bits read zero.
- R9: A write to 0x14 with lane 3 enabled clears the done flag when data bit 24 is one, and clears the abort flag when data bit 28 is one. If a flag is set and cleared in the same cycle, the set wins.
- R10: `irq` is high exactly when (done and enable bit 8) or (abort and enable bit 9). It stays high until the flag is cleared.
- R11: A start with size zero sets the done flag without any bus beat, and the count reads zero.
- R12: A start command issued while a transfer is in progress is ignored. It neither changes the running transfer nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte lane enables for the write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lb_req | output | 1 | Local bus beat request |
| lb_we | output | 1 | Beat is a bus write |
| lb_cs | output | 8 | Chip select for the beat |
| lb_addr | output | 32 | Beat address |
| lb_wdata | output | 32 | Beat write data |
| lb_rdata | input | 32 | Beat read data, valid with `lb_ack` |
| lb_ack | input | 1 | Beat acknowledge |
| fifo_pop | output | 1 | Take one word from the FIFO |
| fifo_rdata | input | 32 | Word at the FIFO head |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_push | output | 1 | Store `fifo_wdata` into the FIFO |
| fifo_wdata | output | 32 | Word to store |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_clr | output | 1 | FIFO reset request |
| irq | output | 1 | Interrupt, level |

## Verification
Two events can land in the same clock edge: the acknowledge of the final beat, which sets the done flag, and a software write-one-to-clear of that flag. To provoke this, the bench stalls its bus model on a one-beat transfer. It then drives the acknowledge and the clearing register write together in one cycle. The expected result is that done stays set and `irq` stays high. A second clear, one cycle later, must then bring both low. Around this case, a size sweep in both directions compares every beat's address, select, direction and data against values computed from the start address.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

    localparam int LBX_CNT_W = 24;
    localparam int LBX_DW    = 32;
    localparam int LBX_BEAT  = 4;

    localparam logic [7:0] OFS_SIZE = 8'h00;
    localparam logic [7:0] OFS_ADDR = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_EN   = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h14;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_BUS   = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic rst_ctl;
        logic rst_fifo;
        logic err_ie;
        logic done_ie;
        logic master;
    } en_t;

    typedef struct packed {
        logic [7:0] cs;
        logic       rd;
        logic       go;
    } ctl_t;

    function automatic logic [31:0] stat_word(input logic done,
                                              input logic abrt,
                                              input logic [LBX_CNT_W-1:0] cnt);
        return {3'b000, abrt, 3'b000, done, cnt};
    endfunction

    function automatic logic [31:0] en_word(input en_t e);
        return {7'b0, e.rst_ctl, 7'b0, e.rst_fifo, 6'b0, e.err_ie, e.done_ie, 7'b0, e.master};
    endfunction

endpackage

// File: rtl/lbx_regfile.sv
module lbx_regfile
    import lbx_pkg::*;
#(
    parameter int CNT_W = LBX_CNT_W,
    parameter int DW    = LBX_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [3:0]       reg_be,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             st_done,
    input  logic             st_abort,
    input  logic [CNT_W-1:0] st_count,
    output logic [CNT_W-1:0] size_q,
    output logic [DW-1:0]    addr_q,
    output ctl_t             ctl_q,
    output en_t              en_q,
    output logic             start_q,
    output logic             clr_done,
    output logic             clr_abort
);

    logic wr_size, wr_addr, wr_ctrl, wr_en, wr_stat;

    assign wr_size = reg_wr && (reg_addr == OFS_SIZE);
    assign wr_addr = reg_wr && (reg_addr == OFS_ADDR);
    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_en   = reg_wr && (reg_addr == OFS_EN);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);

    assign clr_done  = wr_stat && reg_be[3] && reg_wdata[24];
    assign clr_abort = wr_stat && reg_be[3] && reg_wdata[28];

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q  <= '0;
            addr_q  <= '0;
            ctl_q   <= '0;
            en_q    <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= wr_size && reg_be[3] && reg_wdata[24];
            for (int i = 0; i < 3; i++) begin
                if (wr_size && reg_be[i]) size_q[8*i +: 8] <= reg_wdata[8*i +: 8];
            end
            for (int i = 0; i < 4; i++) begin
                if (wr_addr && reg_be[i]) addr_q[8*i +: 8] <= reg_wdata[8*i +: 8];
            end
            if (wr_ctrl) begin
                if (reg_be[3]) ctl_q.cs <= reg_wdata[31:24];
                if (reg_be[2]) ctl_q.rd <= reg_wdata[16];
                if (reg_be[0]) ctl_q.go <= reg_wdata[3];
            end
            if (wr_en) begin
                if (reg_be[0]) en_q.master   <= reg_wdata[0];
                if (reg_be[1]) en_q.done_ie  <= reg_wdata[8];
                if (reg_be[1]) en_q.err_ie   <= reg_wdata[9];
                if (reg_be[2]) en_q.rst_fifo <= reg_wdata[16];
                if (reg_be[3]) en_q.rst_ctl  <= reg_wdata[24];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_SIZE: reg_rdata = 32'(size_q);
            OFS_ADDR: reg_rdata = addr_q;
            OFS_CTRL: reg_rdata = {ctl_q.cs, 7'b0, ctl_q.rd, 12'b0, ctl_q.go, 3'b0};
            OFS_EN:   reg_rdata = en_word(en_q);
            OFS_STAT: reg_rdata = stat_word(st_done, st_abort, st_count);
            default:  reg_rdata = '0;
        endcase
    end

    // R2
    start_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_SIZE && !reg_be[3]) |=> !start_q);

endmodule

// File: rtl/lbx_sequencer.sv
module lbx_sequencer
    import lbx_pkg::*;
#(
    parameter int CNT_W = LBX_CNT_W,
    parameter int DW    = LBX_DW,
    parameter int BEAT  = LBX_BEAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             master,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic [DW-1:0]    cfg_addr,
    input  ctl_t             cfg_ctl,
    output logic             lb_req,
    output logic             lb_we,
    output logic [7:0]       lb_cs,
    output logic [DW-1:0]    lb_addr,
    output logic [DW-1:0]    lb_wdata,
    input  logic [DW-1:0]    lb_rdata,
    input  logic             lb_ack,
    output logic             fifo_pop,
    input  logic [DW-1:0]    fifo_rdata,
    input  logic             fifo_empty,
    output logic             fifo_push,
    output logic [DW-1:0]    fifo_wdata,
    input  logic             fifo_full,
    output logic [CNT_W-1:0] bytes_done,
    output logic             done_set,
    output logic             abort_set
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(BEAT);
    localparam logic [DW-1:0]    ADV  = DW'(BEAT);

    sq_state_e        state;
    logic [CNT_W-1:0] size_l, cnt;
    logic [DW-1:0]    addr_l, wdata_l;
    logic [7:0]       cs_l;
    logic             rd_l;

    logic [CNT_W-1:0] remain, step;
    logic             last, start_ok, under, acked, over;

    assign remain   = size_l - cnt;
    assign last     = remain <= STEP;
    assign step     = last ? remain : STEP;
    assign start_ok = start && master && !hold && (state == SQ_IDLE);
    assign under    = !hold && (state == SQ_ISSUE) && !rd_l && fifo_empty;
    assign acked    = !hold && (state == SQ_BUS) && lb_ack;
    assign over     = acked && rd_l && fifo_full;

    assign fifo_pop   = !hold && (state == SQ_ISSUE) && !rd_l && !fifo_empty;
    assign fifo_push  = acked && rd_l && !fifo_full;
    assign fifo_wdata = lb_rdata;
    assign abort_set  = under || over;
    assign done_set   = (acked && !over && last) || (start_ok && cfg_size == '0);

    assign lb_req     = !hold && (state == SQ_BUS);
    assign lb_we      = !rd_l;
    assign lb_cs      = cs_l;
    assign lb_addr    = addr_l;
    assign lb_wdata   = wdata_l;
    assign bytes_done = cnt;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state   <= SQ_IDLE;
            size_l  <= '0;
            cnt     <= '0;
            addr_l  <= '0;
            wdata_l <= '0;
            cs_l    <= '0;
            rd_l    <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start_ok) begin
                        size_l <= cfg_size;
                        addr_l <= cfg_addr;
                        cs_l   <= cfg_ctl.cs;
                        rd_l   <= cfg_ctl.rd;
                        cnt    <= '0;
                        state  <= (cfg_size == '0) ? SQ_IDLE : SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    if (under) begin
                        state <= SQ_IDLE;
                    end else begin
                        if (!rd_l) wdata_l <= fifo_rdata;
                        state <= SQ_BUS;
                    end
                end
                SQ_BUS: begin
                    if (lb_ack) begin
                        if (over) begin
                            state <= SQ_IDLE;
                        end else begin
                            cnt    <= cnt + step;
                            addr_l <= addr_l + ADV;
                            state  <= last ? SQ_IDLE : SQ_ISSUE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst || hold)
        (lb_req && !lb_ack) |=> (lb_req && $stable(lb_addr)));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bytes_done <= size_l);

    // R5 R6
    pop_push_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_pop && fifo_push));

    // R7
    end_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_set && abort_set));

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        hold |-> (!lb_req && !fifo_pop && !fifo_push));

endmodule

// File: rtl/lbx_status.sv
module lbx_status (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic done_set,
    input  logic abort_set,
    input  logic clr_done,
    input  logic clr_abort,
    input  logic done_ie,
    input  logic err_ie,
    output logic done_q,
    output logic abort_q,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            done_q  <= done_set  || (done_q  && !clr_done);
            abort_q <= abort_set || (abort_q && !clr_abort);
        end
    end

    assign irq = (done_q && done_ie) || (abort_q && err_ie);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst || hold)
        done_set |=> done_q);

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (rst || hold)
        (irq && !clr_done && !clr_abort) |=> (done_q || abort_q));

endmodule

// File: rtl/lbfifo_xfer.sv
module lbfifo_xfer
    import lbx_pkg::*;
#(
    parameter int CNT_W = LBX_CNT_W,
    parameter int DW    = LBX_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [3:0]    reg_be,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          lb_req,
    output logic          lb_we,
    output logic [7:0]    lb_cs,
    output logic [DW-1:0] lb_addr,
    output logic [DW-1:0] lb_wdata,
    input  logic [DW-1:0] lb_rdata,
    input  logic          lb_ack,
    output logic          fifo_pop,
    input  logic [DW-1:0] fifo_rdata,
    input  logic          fifo_empty,
    output logic          fifo_push,
    output logic [DW-1:0] fifo_wdata,
    input  logic          fifo_full,
    output logic          fifo_clr,
    output logic          irq
);

    logic [CNT_W-1:0] size_q, bytes_done;
    logic [DW-1:0]    addr_q;
    ctl_t             ctl_q;
    en_t              en_q;
    logic             start_q, clr_done, clr_abort;
    logic             done_set, abort_set, done_q, abort_q, hold;

    assign hold     = en_q.rst_ctl || en_q.rst_fifo;
    assign fifo_clr = en_q.rst_fifo;

    lbx_regfile #(.CNT_W(CNT_W), .DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_done(done_q), .st_abort(abort_q), .st_count(bytes_done),
        .size_q(size_q), .addr_q(addr_q), .ctl_q(ctl_q), .en_q(en_q),
        .start_q(start_q), .clr_done(clr_done), .clr_abort(clr_abort)
    );

    lbx_sequencer #(.CNT_W(CNT_W), .DW(DW)) u_seq (
        .clk(clk), .rst(rst), .hold(hold), .master(en_q.master),
        .start(start_q), .cfg_size(size_q), .cfg_addr(addr_q), .cfg_ctl(ctl_q),
        .lb_req(lb_req), .lb_we(lb_we), .lb_cs(lb_cs), .lb_addr(lb_addr),
        .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
        .bytes_done(bytes_done), .done_set(done_set), .abort_set(abort_set)
    );

    lbx_status u_stat (
        .clk(clk), .rst(rst), .hold(hold),
        .done_set(done_set), .abort_set(abort_set),
        .clr_done(clr_done), .clr_abort(clr_abort),
        .done_ie(en_q.done_ie), .err_ie(en_q.err_ie),
        .done_q(done_q), .abort_q(abort_q), .irq(irq)
    );

endmodule

// File: tb/lbfifo_xfer_bench.sv
module lbfifo_xfer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lb_req, lb_we, fifo_pop, fifo_push, fifo_clr, irq;
    logic [7:0]  lb_cs;
    logic [31:0] lb_addr, lb_wdata, fifo_wdata;
    logic [31:0] lb_rdata = '0;
    logic        lb_ack, fifo_empty, fifo_full;
    logic [31:0] fifo_rdata;

    logic        ack_auto = 1'b0;
    logic        force_ack = 1'b0;
    logic        stall = 1'b0;
    logic        model_clr = 1'b0;
    int          ack_dly = 0;
    int          avail = 0;
    int          cap = 100;
    int          pop_idx = 0;
    int          push_n = 0;
    int          beat_n = 0;
    int          wait_c = 0;
    logic [31:0] b_addr [16];
    logic        b_we   [16];
    logic [7:0]  b_cs   [16];
    logic [31:0] b_wd   [16];
    logic [31:0] p_log  [16];

    int compared = 0;
    int mismatched = 0;

    assign lb_ack     = ack_auto | force_ack;
    assign fifo_rdata = 32'hC0DE0000 + 32'(pop_idx);
    assign fifo_empty = pop_idx >= avail;
    assign fifo_full  = push_n >= cap;

    lbfifo_xfer u_lbfifo_xfer (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lb_req(lb_req), .lb_we(lb_we),
        .lb_cs(lb_cs), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .lb_ack(lb_ack), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
        .fifo_empty(fifo_empty), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_full(fifo_full), .fifo_clr(fifo_clr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // FIFO model: sampled at the edge, before the design updates
    initial begin
        forever @(posedge clk) begin
            if (model_clr) begin
                pop_idx <= 0;
                push_n  <= 0;
            end else begin
                if (fifo_pop) pop_idx <= pop_idx + 1;
                if (fifo_push) begin
                    p_log[push_n[3:0]] <= fifo_wdata;
                    push_n <= push_n + 1;
                end
            end
        end
    end

    // Bus responder: acts on the falling edge
    initial begin
        forever @(negedge clk) begin
            if (model_clr) begin
                beat_n = 0; wait_c = 0; ack_auto = 1'b0;
            end else if (ack_auto) begin
                ack_auto = 1'b0;
            end else if (lb_req && !stall) begin
                if (wait_c >= ack_dly) begin
                    ack_auto = 1'b1;
                    wait_c = 0;
                    lb_rdata = lb_addr ^ 32'hA5A50000;
                    b_addr[beat_n[3:0]] = lb_addr;
                    b_we[beat_n[3:0]]   = lb_we;
                    b_cs[beat_n[3:0]]   = lb_cs;
                    b_wd[beat_n[3:0]]   = lb_wdata;
                    beat_n = beat_n + 1;
                end else begin
                    wait_c = wait_c + 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched = mismatched + 1;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        compared = compared + 1;
        if (got !== exp) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_model();
        @(negedge clk); model_clr = 1'b1;
        @(negedge clk); model_clr = 1'b0;
    endtask

    task automatic wait_end();
        logic [31:0] st;
        for (int i = 0; i < 2000; i++) begin
            reg_read(8'h14, st);
            if (st[24] || st[28]) break;
        end
    endtask

    task automatic launch(input int size, input logic [31:0] a, input logic [7:0] cs,
                          input logic rd, input int avl, input int cp, input int dly);
        avail = avl; cap = cp; ack_dly = dly;
        clear_model();
        reg_write(8'h04, 4'hF, a);
        reg_write(8'h08, 4'hF, {cs, 7'b0, rd, 12'b0, 1'b1, 3'b0});
        reg_write(8'h00, 4'hF, {8'h01, 24'(size)});
    endtask

    initial begin
        logic [31:0] rv;
        int nb;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            reg_read(8'(i * 4), rv);
            chk("R1 reset register", rv, 32'h0);
        end
        reg_read(8'h14, rv);
        chk("R1 reset status", rv, 32'h0);
        chk("R1 reset irq/req/pop/push", {28'b0, irq, lb_req, fifo_pop, fifo_push}, 32'h0);

        // R2 start ignored without master enable
        reg_write(8'h0C, 4'hF, 32'h00000300);
        launch(8, 32'h3000, 8'h2, 1'b0, 8, 100, 0);
        repeat (20) @(negedge clk);
        chk("R2 no start without master", 32'(beat_n), 32'h0);
        reg_read(8'h14, rv);
        chk("R2 status idle without master", rv, 32'h0);

        // R2 low lanes only: size written, no start
        reg_write(8'h0C, 4'hF, 32'h00000301);
        clear_model();
        reg_write(8'h00, 4'b0111, 32'h01000008);
        repeat (20) @(negedge clk);
        chk("R2 low-lane write does not start", 32'(beat_n), 32'h0);
        reg_read(8'h00, rv);
        chk("R2 size readback", rv, 32'h8);

        // R3 R4 R5 R6 R8 R10 R11 sweep of sizes and directions
        for (int s = 0; s <= 13; s++) begin
            for (int d = 0; d < 2; d++) begin
                a = 32'h1000 + 32'(s * 64);
                nb = (s + 3) / 4;
                launch(s, a, 8'(s + 1), d[0], 16, 100, s % 3);
                wait_end();
                reg_read(8'h14, rv);
                chk("R4 R8 R11 status after transfer", rv, {8'h01, 24'(s)});
                chk("R4 R11 beat count", 32'(beat_n), 32'(nb));
                for (int k = 0; k < nb; k++) begin
                    chk("R3 beat address", b_addr[k], a + 32'(4 * k));
                    chk("R3 beat direction", {31'b0, b_we[k]}, {31'b0, ~d[0]});
                    chk("R3 beat chip select", {24'b0, b_cs[k]}, 32'(s + 1));
                    if (d == 0) chk("R5 beat write data", b_wd[k], 32'hC0DE0000 + 32'(k));
                    else        chk("R6 pushed word", p_log[k], (a + 32'(4 * k)) ^ 32'hA5A50000);
                end
                if (d == 0) chk("R5 pop count", 32'(pop_idx), 32'(nb));
                else        chk("R6 push count", 32'(push_n), 32'(nb));
                chk("R10 irq on done", {31'b0, irq}, 32'h1);
                reg_write(8'h14, 4'b1000, 32'h01000000);
                reg_read(8'h14, rv);
                chk("R9 done cleared", rv, {8'h00, 24'(s)});
                chk("R10 irq after clear", {31'b0, irq}, 32'h0);
            end
        end

        // R7 underflow in write direction
        launch(16, 32'h4000, 8'h5, 1'b0, 2, 100, 1);
        wait_end();
        reg_read(8'h14, rv);
        chk("R7 underflow status", rv, {8'h10, 24'd8});
        chk("R7 underflow beats", 32'(beat_n), 32'd2);
        chk("R10 irq on abort", {31'b0, irq}, 32'h1);
        reg_write(8'h14, 4'b1000, 32'h10000000);
        reg_read(8'h14, rv);
        chk("R9 abort cleared", rv, {8'h00, 24'd8});

        // R7 overflow in read direction, error interrupt masked
        reg_write(8'h0C, 4'hF, 32'h00000101);
        launch(12, 32'h5000, 8'h6, 1'b1, 0, 1, 0);
        wait_end();
        reg_read(8'h14, rv);
        chk("R7 overflow status", rv, {8'h10, 24'd4});
        chk("R7 overflow pushes", 32'(push_n), 32'd1);
        chk("R10 masked abort irq", {31'b0, irq}, 32'h0);
        reg_write(8'h14, 4'b1000, 32'h10000000);
        reg_write(8'h0C, 4'hF, 32'h00000301);

        // R12 start while busy is ignored
        launch(16, 32'h2000, 8'h7, 1'b1, 0, 100, 6);
        repeat (5) @(negedge clk);
        reg_write(8'h00, 4'b1000, 32'h01000000);
        wait_end();
        repeat (30) @(negedge clk);
        chk("R12 beats of first transfer only", 32'(beat_n), 32'd4);
        chk("R12 first address kept", b_addr[0], 32'h2000);
        chk("R12 last address", b_addr[3], 32'h200C);
        reg_read(8'h14, rv);
        chk("R12 status", rv, {8'h01, 24'd16});
        reg_write(8'h14, 4'b1000, 32'h01000000);

        // R1 reset bits stop a running transfer
        launch(40, 32'h6000, 8'h8, 1'b1, 0, 100, 4);
        repeat (12) @(negedge clk);
        reg_write(8'h0C, 4'hF, 32'h01010000);
        chk("R1 fifo_clr while held", {31'b0, fifo_clr}, 32'h1);
        chk("R1 no request while held", {31'b0, lb_req}, 32'h0);
        reg_read(8'h14, rv);
        chk("R1 status cleared while held", rv, 32'h0);
        reg_read(8'h0C, rv);
        chk("R1 enable readback", rv, 32'h01010000);
        reg_write(8'h0C, 4'hF, 32'h00000301);
        chk("R1 fifo_clr released", {31'b0, fifo_clr}, 32'h0);

        // R9 final acknowledge and clear in the same cycle
        stall = 1'b1;
        launch(4, 32'h7000, 8'h9, 1'b0, 4, 100, 0);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (lb_req) break;
        end
        reg_addr = 8'h14; reg_be = 4'b1000; reg_wdata = 32'h01000000;
        reg_wr = 1'b1; force_ack = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; force_ack = 1'b0;
        stall = 1'b0;
        reg_read(8'h14, rv);
        chk("R9 set wins over same-cycle clear", rv, {8'h01, 24'd4});
        chk("R9 irq after collision", {31'b0, irq}, 32'h1);
        reg_write(8'h14, 4'b1000, 32'h01000000);
        reg_read(8'h14, rv);
        chk("R9 later clear", rv, {8'h00, 24'd4});
        chk("R10 irq low after later clear", {31'b0, irq}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule